// File: doc/BRIEF.md
# CAN Controller Register Block

This block is the byte-wide software view of a CAN controller. It sits between a simple single-cycle CPU port and a CAN protocol engine. The CPU side has an address, a write enable, write data and combinational read data. The engine side is modelled by event inputs: transmission done, arbitration lost, data frame received, remote frame received, and an 8-bit vector of error detections.

The block holds three registers.

- **Control register.** It carries the enable, software reset and dual-filter settings. It also issues transmit and reconfigure requests to the engine as single-cycle pulses. A transmit request stays visible as a pending bit until the engine reports an outcome.
- **Status register.** It collects event flags that software acknowledges by writing 1 to them. While the received-frame flag is set, the block tells the engine not to overwrite received data.
- **Error-type register.** It latches each kind of bus error separately.

Top module: `can_csr_top`

## Requirements
- R1: After reset the control, status and error-type registers all read 0x00, txPulse and cfgPulse are low, and rxUpdateEn is high.
- R2: Control bits 7 (ifEnable), 6 (swReset) and 3 (dualFilter, 1 = dual) are stored on a write, read back, and drive their outputs. Bits 5, 4, 1 and 0 always read 0.
- R3: A control write with bit 2 = 1, bit 7 = 1 and bit 6 = 0 raises txPulse for exactly the one cycle after the write edge. Control bit 2 then reads 1 (pending). The same write with bit 7 = 0 gives no pulse and no pending bit.
- R4: Pending control bit 2 is cleared by any of four outcomes: evTxDone, evArbLost, any nonzero errSet, or software reset (bit 6 written as 1 or held at 1).
- R5: A control write with bit 5 = 1 raises cfgPulse for exactly the one cycle after the write edge. This happens whatever the enable bit is, and bit 5 reads 0.
- R6: Status bit 7 is set by evRxRemote, bit 6 by evRxFrame and bit 5 by evTxDone. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A set event in the same cycle as the clear wins.
- R7: rxUpdateEn is low exactly while status bit 6 is set.
- R8: evRxFrame arriving while status bit 6 is already set sets status bit 4 (overflow). Bit 4 stays set until software writes 1 to it.
- R9: Each errSet bit sets the matching error-type bit: 7 bus-off, 6 error-active, 5 error-passive, 4 CRC, 3 acknowledge, 2 form, 1 stuff, 0 bit. Any nonzero errSet also sets status bit 3. Both registers are cleared by writing 1 to a bit.
- R10: Status bit 2 is set by evArbLost and cleared by evTxDone. CPU writes have no effect on it.
- R11: Address 0 is control, 1 is status and 2 is error-type. Any other address reads 0x00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Register address |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| evTxDone | input | 1 | Engine: transmission completed |
| evArbLost | input | 1 | Engine: arbitration lost |
| evRxFrame | input | 1 | Engine: data frame received |
| evRxRemote | input | 1 | Engine: remote frame received |
| errSet | input | 8 | Engine: error detections, one bit per error type |
| ifEnable | output | 1 | Interface enable |
| swReset | output | 1 | Engine held in software reset |
| dualFilter | output | 1 | 1 = dual acceptance filter mode |
| txPulse | output | 1 | One-cycle transmit request |
| cfgPulse | output | 1 | One-cycle reconfigure request |
| rxUpdateEn | output | 1 | Engine may update received data |

## Verification
The bench uses the default parameters: ADDR_W = 2, with control, status and error-type at addresses 0, 1 and 2. That leaves address 3 free, so reads and writes to an unmapped location can be exercised. The bench drives every transmit outcome separately against a pending request. It also places an event in the same cycle as a software clear, to check the set-over-clear priority and the overflow rule of the receive freeze.

// File: rtl/can_csr_pkg.sv
package can_csr_pkg;
  localparam int BYTE_W = 8;

  // Control bit positions
  localparam int CB_EN   = 7;
  localparam int CB_SRST = 6;
  localparam int CB_CFG  = 5;
  localparam int CB_DUAL = 3;
  localparam int CB_TX   = 2;

  // Status bit positions
  localparam int SB_REM = 7;
  localparam int SB_RX  = 6;
  localparam int SB_TXD = 5;
  localparam int SB_OVF = 4;
  localparam int SB_ERR = 3;
  localparam int SB_ARB = 2;

  typedef struct packed {
    logic              ctrlWr;   // write to control register
    logic              enVal;    // written enable value
    logic              srstVal;  // written software-reset value
    logic              dualVal;  // written filter-mode value
    logic              txReq;    // accepted transmit request
    logic              cfgReq;   // reconfigure request
    logic [BYTE_W-1:0] statClr;  // write-1-to-clear mask for status
    logic [BYTE_W-1:0] errClr;   // write-1-to-clear mask for error type
  } csr_strobe_t;
endpackage

// File: rtl/can_csr_decode.sv
module can_csr_decode
  import can_csr_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int ERR_ADDR  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BYTE_W-1:0] busWdata,
  output csr_strobe_t       stb,
  output logic              txPulse,
  output logic              cfgPulse
);
  logic hitCtrl, hitStat, hitErr;

  assign hitCtrl = busWe && (busAddr == ADDR_W'(CTRL_ADDR));
  assign hitStat = busWe && (busAddr == ADDR_W'(STAT_ADDR));
  assign hitErr  = busWe && (busAddr == ADDR_W'(ERR_ADDR));

  always_comb begin
    stb         = '0;
    stb.ctrlWr  = hitCtrl;
    stb.enVal   = busWdata[CB_EN];
    stb.srstVal = busWdata[CB_SRST];
    stb.dualVal = busWdata[CB_DUAL];
    // A transmit request counts only if the new value leaves the interface enabled and out of reset
    stb.txReq   = hitCtrl && busWdata[CB_TX] && busWdata[CB_EN] && !busWdata[CB_SRST];
    stb.cfgReq  = hitCtrl && busWdata[CB_CFG];
    stb.statClr = hitStat ? busWdata : '0;
    stb.errClr  = hitErr  ? busWdata : '0;
  end

  // Requests leave as registered one-cycle pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPulse  <= 1'b0;
      cfgPulse <= 1'b0;
    end else begin
      txPulse  <= stb.txReq;
      cfgPulse <= stb.cfgReq;
    end
  end

  // R5: after one pulse, another one needs a fresh request
  a_r5_cfg_single : assert property (@(posedge clk) disable iff (!rstN)
    cfgPulse && !stb.cfgReq |=> !cfgPulse);
endmodule

// File: rtl/can_csr_regs.sv
module can_csr_regs
  import can_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  csr_strobe_t       stb,
  input  logic              evTxDone,
  input  logic              evArbLost,
  input  logic              evRxFrame,
  input  logic              evRxRemote,
  input  logic [BYTE_W-1:0] errSet,
  output logic [BYTE_W-1:0] ctrlQ,
  output logic [BYTE_W-1:0] statQ,
  output logic [BYTE_W-1:0] errQ,
  output logic              rxUpdateEn
);
  localparam int STICKY_LO = SB_ERR;
  localparam int STICKY_HI = SB_REM;

  logic enQ, srstQ, dualQ, txPend, arbQ;
  logic anyErr, txClr;
  logic [BYTE_W-1:0] stickySet;

  assign anyErr = |errSet;
  assign txClr  = evTxDone || evArbLost || anyErr || srstQ || (stb.ctrlWr && stb.srstVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      srstQ  <= 1'b0;
      dualQ  <= 1'b0;
      txPend <= 1'b0;
      arbQ   <= 1'b0;
    end else begin
      if (stb.ctrlWr) begin
        enQ   <= stb.enVal;
        srstQ <= stb.srstVal;
        dualQ <= stb.dualVal;
      end
      if (stb.txReq)  txPend <= 1'b1;
      else if (txClr) txPend <= 1'b0;
      if (evArbLost)     arbQ <= 1'b1;
      else if (evTxDone) arbQ <= 1'b0;
    end
  end

  always_comb begin
    stickySet         = '0;
    stickySet[SB_REM] = evRxRemote;
    stickySet[SB_RX]  = evRxFrame;
    stickySet[SB_TXD] = evTxDone;
    stickySet[SB_OVF] = evRxFrame && statQ[SB_RX];
    stickySet[SB_ERR] = anyErr;
  end

  // Event-set, write-1-clear flags; a set event beats a clear in the same cycle
  for (genvar i = 0; i < BYTE_W; i++) begin : g_stat
    if (i >= STICKY_LO && i <= STICKY_HI) begin : g_sticky
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 statQ[i] <= 1'b0;
        else if (stickySet[i])     statQ[i] <= 1'b1;
        else if (stb.statClr[i])   statQ[i] <= 1'b0;
      end
    end else if (i == SB_ARB) begin : g_arb
      assign statQ[i] = arbQ;
    end else begin : g_zero
      assign statQ[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= '0;
    else       errQ <= (errQ & ~stb.errClr) | errSet;
  end

  always_comb begin
    ctrlQ          = '0;
    ctrlQ[CB_EN]   = enQ;
    ctrlQ[CB_SRST] = srstQ;
    ctrlQ[CB_DUAL] = dualQ;
    ctrlQ[CB_TX]   = txPend;
  end

  assign rxUpdateEn = !statQ[SB_RX];

  a_r4_tx_outcome_clears : assert property (@(posedge clk) disable iff (!rstN)
    txPend && (evTxDone || evArbLost || anyErr) && !stb.txReq |=> !ctrlQ[CB_TX]);
  a_r8_ovf_on_busy_rx : assert property (@(posedge clk) disable iff (!rstN)
    evRxFrame && statQ[SB_RX] |=> statQ[SB_OVF]);
  a_r8_ovf_sticky : assert property (@(posedge clk) disable iff (!rstN)
    statQ[SB_OVF] && !stb.statClr[SB_OVF] |=> statQ[SB_OVF]);
  a_r9_err_flag : assert property (@(posedge clk) disable iff (!rstN)
    anyErr |=> statQ[SB_ERR] && ((errQ & $past(errSet)) == $past(errSet)));
  a_r10_arb_hold : assert property (@(posedge clk) disable iff (!rstN)
    !evArbLost && !evTxDone |=> $stable(statQ[SB_ARB]));
endmodule

// File: rtl/can_csr_top.sv
module can_csr_top
  import can_csr_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int ERR_ADDR  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              evTxDone,
  input  logic              evArbLost,
  input  logic              evRxFrame,
  input  logic              evRxRemote,
  input  logic [7:0]        errSet,
  output logic              ifEnable,
  output logic              swReset,
  output logic              dualFilter,
  output logic              txPulse,
  output logic              cfgPulse,
  output logic              rxUpdateEn
);
  csr_strobe_t       stb;
  logic [BYTE_W-1:0] ctrlQ, statQ, errQ;

  can_csr_decode #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR), .ERR_ADDR(ERR_ADDR)
  ) u_decode (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .stb(stb), .txPulse(txPulse), .cfgPulse(cfgPulse)
  );

  can_csr_regs u_regs (
    .clk(clk), .rstN(rstN), .stb(stb),
    .evTxDone(evTxDone), .evArbLost(evArbLost), .evRxFrame(evRxFrame), .evRxRemote(evRxRemote),
    .errSet(errSet), .ctrlQ(ctrlQ), .statQ(statQ), .errQ(errQ), .rxUpdateEn(rxUpdateEn)
  );

  always_comb begin
    if (busAddr == ADDR_W'(CTRL_ADDR))      busRdata = ctrlQ;
    else if (busAddr == ADDR_W'(STAT_ADDR)) busRdata = statQ;
    else if (busAddr == ADDR_W'(ERR_ADDR))  busRdata = errQ;
    else                                    busRdata = '0;
  end

  assign ifEnable   = ctrlQ[CB_EN];
  assign swReset    = ctrlQ[CB_SRST];
  assign dualFilter = ctrlQ[CB_DUAL];

  // R3: a transmit pulse always goes with a pending request
  a_r3_pulse_pending : assert property (@(posedge clk) disable iff (!rstN)
    txPulse |-> ctrlQ[CB_TX]);
  // R3: no transmit request leaves while disabled or in software reset
  a_r3_pulse_gated : assert property (@(posedge clk) disable iff (!rstN)
    txPulse |-> ifEnable && !swReset);
endmodule

// File: tb/can_csr_top_tb.sv
module can_csr_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       evTxDone = 1'b0, evArbLost = 1'b0, evRxFrame = 1'b0, evRxRemote = 1'b0;
  logic [7:0] errSet = '0;
  logic       ifEnable, swReset, dualFilter, txPulse, cfgPulse, rxUpdateEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_ERR = 2'd2, A_NONE = 2'd3;

  always #10 clk = ~clk;

  can_csr_top u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .evTxDone(evTxDone), .evArbLost(evArbLost), .evRxFrame(evRxFrame),
    .evRxRemote(evRxRemote), .errSet(errSet), .ifEnable(ifEnable), .swReset(swReset),
    .dualFilter(dualFilter), .txPulse(txPulse), .cfgPulse(cfgPulse), .rxUpdateEn(rxUpdateEn)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    busAddr = a;
    #1 v = busRdata;
  endtask

  task automatic chkReg(input string tag, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  // Write in one cycle; returns at the negedge after the write edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  // One-cycle engine events
  task automatic ev(input logic txd, input logic arb, input logic rxf, input logic rem,
                    input logic [7:0] es);
    @(negedge clk);
    evTxDone = txd; evArbLost = arb; evRxFrame = rxf; evRxRemote = rem; errSet = es;
    @(negedge clk);
    evTxDone = 0; evArbLost = 0; evRxFrame = 0; evRxRemote = 0; errSet = '0;
  endtask

  task automatic testReset();
    chkReg("R1 ctrl", A_CTRL, 8'h00);
    chkReg("R1 stat", A_STAT, 8'h00);
    chkReg("R1 err", A_ERR, 8'h00);
    chk("R1 pulses", {6'd0, txPulse, cfgPulse}, 8'h00);
    chk("R1 rxUpdateEn", {7'd0, rxUpdateEn}, 8'h01);
  endtask

  task automatic testCtrlFields();
    wr(A_CTRL, 8'h8B);
    chkReg("R2 ctrl readback low bits zero", A_CTRL, 8'h88);
    chk("R2 outputs en/srst/dual", {5'd0, ifEnable, swReset, dualFilter}, 8'h05);
    wr(A_CTRL, 8'h98);
    chkReg("R2 bit4 reads zero", A_CTRL, 8'h88);
    wr(A_CTRL, 8'h40);
    chk("R2 swReset out", {5'd0, ifEnable, swReset, dualFilter}, 8'h02);
  endtask

  task automatic testCfg();
    wr(A_CTRL, 8'h20);
    chk("R5 cfgPulse high", {7'd0, cfgPulse}, 8'h01);
    chkReg("R5 bit5 reads zero", A_CTRL, 8'h00);
    @(negedge clk);
    chk("R5 cfgPulse one cycle", {7'd0, cfgPulse}, 8'h00);
  endtask

  task automatic testTx();
    wr(A_CTRL, 8'h84);
    chk("R3 txPulse high", {7'd0, txPulse}, 8'h01);
    chkReg("R3 pending reads 1", A_CTRL, 8'h84);
    @(negedge clk);
    chk("R3 txPulse one cycle", {7'd0, txPulse}, 8'h00);
    chkReg("R3 pending holds", A_CTRL, 8'h84);
    ev(1, 0, 0, 0, 8'h00);
    chkReg("R4 cleared by txDone", A_CTRL, 8'h80);
    chkReg("R6 tx done flag", A_STAT, 8'h20);
    wr(A_STAT, 8'hFF);
    chkReg("R6 W1C", A_STAT, 8'h00);
    wr(A_CTRL, 8'h04);
    chk("R3 disabled no pulse", {7'd0, txPulse}, 8'h00);
    chkReg("R3 disabled not pending", A_CTRL, 8'h00);
  endtask

  task automatic testTxClears();
    wr(A_CTRL, 8'h84);
    ev(0, 1, 0, 0, 8'h00);
    chkReg("R4 cleared by arbLost", A_CTRL, 8'h80);
    chkReg("R10 arb lost bit", A_STAT, 8'h04);
    wr(A_CTRL, 8'h84);
    ev(0, 0, 0, 0, 8'h01);
    chkReg("R4 cleared by error", A_CTRL, 8'h80);
    chkReg("R9 err flag in status", A_STAT, 8'h0C);
    chkReg("R9 bit error latched", A_ERR, 8'h01);
    wr(A_CTRL, 8'h84);
    wr(A_CTRL, 8'hC4);
    chk("R3 no pulse in swReset", {7'd0, txPulse}, 8'h00);
    chkReg("R4 cleared by swReset", A_CTRL, 8'hC0);
  endtask

  task automatic testArb();
    wr(A_STAT, 8'hFF);
    chkReg("R10 write ignored on arb bit", A_STAT, 8'h04);
    ev(1, 0, 0, 0, 8'h00);
    chkReg("R10 cleared by txDone", A_STAT, 8'h20);
    wr(A_STAT, 8'hFF);
    chkReg("R6 W1C all", A_STAT, 8'h00);
  endtask

  task automatic testErr();
    wr(A_ERR, 8'h00);
    chkReg("R9 write 0 no effect", A_ERR, 8'h01);
    wr(A_ERR, 8'h01);
    chkReg("R9 W1C", A_ERR, 8'h00);
    ev(0, 0, 0, 0, 8'h90);
    chkReg("R9 bus-off and CRC", A_ERR, 8'h90);
    wr(A_ERR, 8'h10);
    chkReg("R9 partial clear", A_ERR, 8'h80);
    chkReg("R9 status flag", A_STAT, 8'h08);
    wr(A_STAT, 8'h08);
    chkReg("R9 status flag cleared", A_STAT, 8'h00);
  endtask

  task automatic testRx();
    ev(0, 0, 1, 0, 8'h00);
    chkReg("R6 rx flag", A_STAT, 8'h40);
    chk("R7 freeze", {7'd0, rxUpdateEn}, 8'h00);
    ev(0, 0, 0, 1, 8'h00);
    chkReg("R6 remote flag", A_STAT, 8'hC0);
    ev(0, 0, 1, 0, 8'h00);
    chkReg("R8 overflow set", A_STAT, 8'hD0);
    wr(A_STAT, 8'h40);
    chkReg("R8 overflow sticky", A_STAT, 8'h90);
    chk("R7 unfrozen", {7'd0, rxUpdateEn}, 8'h01);
    wr(A_STAT, 8'h00);
    chkReg("R6 write 0 no effect", A_STAT, 8'h90);
    wr(A_STAT, 8'h90);
    chkReg("R8 overflow cleared", A_STAT, 8'h00);
    // event and clear in the same cycle
    @(negedge clk);
    busAddr = A_STAT; busWdata = 8'h40; busWe = 1'b1; evRxFrame = 1'b1;
    @(negedge clk);
    busWe = 1'b0; evRxFrame = 1'b0;
    chkReg("R6 set wins over clear", A_STAT, 8'h40);
    wr(A_STAT, 8'h40);
  endtask

  task automatic testUnmapped();
    wr(A_CTRL, 8'h88);
    wr(A_NONE, 8'hFF);
    chkReg("R11 unmapped reads 0", A_NONE, 8'h00);
    chkReg("R11 ctrl untouched", A_CTRL, 8'h88);
    chkReg("R11 stat untouched", A_STAT, 8'h00);
    chkReg("R11 err untouched", A_ERR, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCtrlFields();
    testCfg();
    testTx();
    testTxClears();
    testArb();
    testErr();
    testRx();
    testUnmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule